// File: doc/BRIEF.md
# DMA Graceful Stop and Transmit Poll Controller

This controller handles two jobs for a network DMA engine. The first is the orderly halt of each direction. When software writes the DMA control word with a stop request for receive or transmit, the controller reports completion of that stop. It does so at once if that direction has no frame in progress. Otherwise it waits until the frame in progress finishes. Each completion is a one-cycle set pulse into the event register. The same pulse also raises the error-class interrupt, but only if that direction's enable bit in the interrupt mask is set.

The second job is the transmit poll. Every control write that leaves the poll-disable bit clear restarts a tick timer. The timer runs for one poll period, which is the system clock divided down to the poll rate (100 per second by default). Each time the timer expires, it asks for a walk of transmit ring 0 with a one-cycle pulse, unless a transmit stop is set at that moment. The timer then rearms for another period. If poll-disable is set when the timer expires, the timer stops.

Descriptor processing and the register bank are outside this block. Their inputs are modelled as a write strobe with the control fields, frame-busy levels and mask bits.

Top module: `gspoll_ctrl`

## Requirements
- R1: A control write with the receive-stop bit set while `rx_busy_i` is low produces a one-cycle `rx_stop_done_o` pulse in the cycle after the write edge.
- R2: A control write with the receive-stop bit set while `rx_busy_i` is high produces no pulse at the write. `rx_stop_done_o` pulses once, in the cycle after the first edge at which `rx_busy_i` is sampled low again.
- R3: Transmit stop behaves as in R1 and R2, using `ctl_tx_stop_i`, `tx_busy_i` and `tx_stop_done_o`.
- R4: A pending (deferred) stop is cancelled when a later control write clears that stop bit before the frame ends. No completion pulse follows when busy falls.
- R5: `err_irq_set_o` is high exactly in the cycles where (`rx_stop_done_o` and `rx_stop_en_i`) or (`tx_stop_done_o` and `tx_stop_en_i`).
- R6: Let T = CLK_HZ / POLL_HZ clock cycles. A control write with `ctl_poll_off_i` low reloads the poll timer. `tx_walk_o` then pulses T cycles after that write edge, and every T cycles after that. A later such write restarts the phase.
- R7: While the latched transmit-stop bit is set, timer expiries produce no `tx_walk_o` pulse, but the timer keeps rearming. Walks resume once the bit is cleared.
- R8: Once a control write sets `ctl_poll_off_i`, the next expiry does not rearm the timer, and no further `tx_walk_o` pulses appear.
- R9: After reset, all outputs are low, and no walk happens until a control write enables polling.
- R10: `rx_stop_done_o`, `tx_stop_done_o` and `tx_walk_o` are pulses that last one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_i | input | 1 | Control-word write strobe |
| ctl_rx_stop_i | input | 1 | Written receive graceful-stop bit |
| ctl_tx_stop_i | input | 1 | Written transmit graceful-stop bit |
| ctl_poll_off_i | input | 1 | Written poll-disable (wait) bit |
| rx_busy_i | input | 1 | Receive frame in progress |
| tx_busy_i | input | 1 | Transmit frame in progress |
| rx_stop_en_i | input | 1 | Interrupt enable for receive-stop completion |
| tx_stop_en_i | input | 1 | Interrupt enable for transmit-stop completion |
| rx_stop_done_o | output | 1 | Receive-stop-complete event set pulse |
| tx_stop_done_o | output | 1 | Transmit-stop-complete event set pulse |
| err_irq_set_o | output | 1 | Error-class interrupt raise pulse |
| tx_walk_o | output | 1 | Request to walk transmit ring 0 |

## Verification
The assertions check properties on every cycle:
- a completion never appears while its frame was busy at the deciding edge, or while its stop bit is clear;
- the interrupt pulse always has a completion behind it;
- a walk never fires while transmit is stopped or polling is disabled;
- the timer count stays within one period, and walks never come back to back.

Only the bench's scenarios can show the rest:
- the exact cycle of each completion;
- cancellation of a deferred stop;
- the walk period and its restart on a rewrite;
- the end of polling after poll-disable.

The bench sweeps all 64 combinations of stop bits, busy levels and mask bits.

// File: rtl/gspoll_pkg.sv
package gspoll_pkg;

    // Latched control word fields
    typedef struct packed {
        logic poll_off;
        logic tx_stop;
        logic rx_stop;
    } dma_ctl_t;

    localparam int unsigned NUM_DIR = 2;
    localparam int unsigned DIR_RX  = 0;
    localparam int unsigned DIR_TX  = 1;

    // Poll period in clock cycles, never below one
    function automatic int unsigned poll_period(input longint unsigned clk_hz,
                                                input longint unsigned rate_hz);
        longint unsigned q;
        q = (rate_hz == 0) ? 1 : clk_hz / rate_hz;
        if (q < 1) q = 1;
        return int'(q);
    endfunction

    function automatic logic stop_field(input dma_ctl_t c, input int unsigned dir);
        return (dir == DIR_RX) ? c.rx_stop : c.tx_stop;
    endfunction

endpackage

// File: rtl/gspoll_stop_seq.sv
module gspoll_stop_seq (
    input  logic clk,
    input  logic rst,
    input  logic wr_i,
    input  logic stop_req_i,
    input  logic busy_i,
    output logic done_o
);
    logic busy_q;
    logic pending_q;
    logic done_q;
    logic busy_fall;

    assign busy_fall = busy_q & ~busy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            pending_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            busy_q <= busy_i;
            if (wr_i) begin
                // a new write decides afresh: complete now, defer, or cancel
                done_q    <= stop_req_i & ~busy_i;
                pending_q <= stop_req_i & busy_i;
            end else begin
                done_q <= pending_q & busy_fall;
                if (busy_fall) pending_q <= 1'b0;
            end
        end
    end

    assign done_o = done_q;

    AST_DONE_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(~busy_i)); // R2

    AST_PEND_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        pending_q |-> busy_q); // R4

endmodule

// File: rtl/gspoll_poll_timer.sv
module gspoll_poll_timer #(
    parameter int unsigned TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic poll_off_i,
    input  logic tx_stop_i,
    output logic walk_o
);
    localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LOAD = CW'(TICKS - 1);

    logic          run_q;
    logic [CW-1:0] cnt_q;
    logic          walk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            walk_q <= 1'b0;
        end else begin
            walk_q <= 1'b0;
            if (arm_i) begin
                run_q <= 1'b1;
                cnt_q <= LOAD;
            end else if (run_q) begin
                if (cnt_q == '0) begin
                    if (!poll_off_i) begin
                        walk_q <= ~tx_stop_i;
                        cnt_q  <= LOAD;
                    end else begin
                        run_q <= 1'b0;
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign walk_o = walk_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LOAD); // R6

    AST_WALK_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
        walk_o |-> $past(run_q)); // R8

    generate
        if (TICKS > 1) begin : g_gap
            AST_WALK_SINGLE: assert property (@(posedge clk) disable iff (rst)
                walk_o |=> ~walk_o); // R10
        end
    endgenerate

endmodule

// File: rtl/gspoll_ctrl.sv
module gspoll_ctrl
    import gspoll_pkg::*;
#(
    parameter longint unsigned CLK_HZ  = 100_000_000,
    parameter longint unsigned POLL_HZ = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic ctl_wr_i,
    input  logic ctl_rx_stop_i,
    input  logic ctl_tx_stop_i,
    input  logic ctl_poll_off_i,
    input  logic rx_busy_i,
    input  logic tx_busy_i,
    input  logic rx_stop_en_i,
    input  logic tx_stop_en_i,
    output logic rx_stop_done_o,
    output logic tx_stop_done_o,
    output logic err_irq_set_o,
    output logic tx_walk_o
);
    localparam int unsigned TICKS = poll_period(CLK_HZ, POLL_HZ);

    dma_ctl_t ctl_q, ctl_wdata, ctl_nxt;
    logic [NUM_DIR-1:0] busy_v, en_v, done_v;

    assign ctl_wdata = '{poll_off: ctl_poll_off_i, tx_stop: ctl_tx_stop_i,
                         rx_stop: ctl_rx_stop_i};
    assign ctl_nxt   = ctl_wr_i ? ctl_wdata : ctl_q;

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_nxt;
    end

    assign busy_v[DIR_RX] = rx_busy_i;
    assign busy_v[DIR_TX] = tx_busy_i;
    assign en_v[DIR_RX]   = rx_stop_en_i;
    assign en_v[DIR_TX]   = tx_stop_en_i;

    generate
        for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
            gspoll_stop_seq u_seq (
                .clk        (clk),
                .rst        (rst),
                .wr_i       (ctl_wr_i),
                .stop_req_i (stop_field(ctl_wdata, d)),
                .busy_i     (busy_v[d]),
                .done_o     (done_v[d])
            );
        end
    endgenerate

    gspoll_poll_timer #(.TICKS(TICKS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .arm_i      (ctl_wr_i & ~ctl_poll_off_i),
        .poll_off_i (ctl_nxt.poll_off),
        .tx_stop_i  (ctl_nxt.tx_stop),
        .walk_o     (tx_walk_o)
    );

    assign rx_stop_done_o = done_v[DIR_RX];
    assign tx_stop_done_o = done_v[DIR_TX];
    assign err_irq_set_o  = |(done_v & en_v);

    AST_RX_DONE_STOPPED: assert property (@(posedge clk) disable iff (rst)
        rx_stop_done_o |-> ctl_q.rx_stop); // R1

    AST_TX_DONE_STOPPED: assert property (@(posedge clk) disable iff (rst)
        tx_stop_done_o |-> ctl_q.tx_stop); // R3

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        err_irq_set_o |-> (rx_stop_done_o | tx_stop_done_o)); // R5

    AST_WALK_NOT_HALTED: assert property (@(posedge clk) disable iff (rst)
        tx_walk_o |-> (~ctl_q.tx_stop & ~ctl_q.poll_off)); // R7

endmodule

// File: tb/gspoll_ctrl_test.sv
module gspoll_ctrl_test;
    localparam longint unsigned CLK_HZ  = 1000;
    localparam longint unsigned POLL_HZ = 100;
    localparam int T = int'(CLK_HZ / POLL_HZ);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr = 0, rs = 0, ts = 0, po = 1, rb = 0, tb = 0, mr = 0, mt = 0;
    logic rdone, tdone, irq, walk;
    int total = 0, bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    gspoll_ctrl #(.CLK_HZ(CLK_HZ), .POLL_HZ(POLL_HZ)) uut (
        .clk(clk), .rst(rst), .ctl_wr_i(wr), .ctl_rx_stop_i(rs),
        .ctl_tx_stop_i(ts), .ctl_poll_off_i(po), .rx_busy_i(rb),
        .tx_busy_i(tb), .rx_stop_en_i(mr), .tx_stop_en_i(mt),
        .rx_stop_done_o(rdone), .tx_stop_done_o(tdone),
        .err_irq_set_o(irq), .tx_walk_o(walk)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // drive one control write; returns at the negedge after the write edge
    task automatic wr_ctl(input logic r, input logic t, input logic p,
                          input logic b_r, input logic b_t,
                          input logic m_r, input logic m_t);
        @(negedge clk);
        wr = 1; rs = r; ts = t; po = p; rb = b_r; tb = b_t; mr = m_r; mt = m_t;
        @(negedge clk);
        wr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R9: quiet after reset
        for (int i = 0; i < 2 * T; i++) begin
            @(negedge clk);
            chk("R9 outputs idle", {rdone, tdone, irq, walk}, 0);
        end

        // R1 R3 R5 R10: sweep stop bits, busy levels, masks
        for (int v = 0; v < 64; v++) begin
            logic [5:0] b;
            int er, et;
            b = 6'(v);
            wr_ctl(b[0], b[1], 1'b1, b[2], b[3], b[4], b[5]);
            er = (b[0] & ~b[2]) ? 1 : 0;
            et = (b[1] & ~b[3]) ? 1 : 0;
            chk("R1 rx immediate", rdone, er);
            chk("R3 tx immediate", tdone, et);
            chk("R5 irq gate", irq, (er & b[4]) | (et & b[5]));
            @(negedge clk);
            chk("R10 rx one cycle", rdone, 0);
            chk("R10 tx one cycle", tdone, 0);
        end
        wr_ctl(0, 0, 1, 0, 0, 0, 0);
        @(negedge clk);

        // R2: deferred receive stop
        wr_ctl(1, 0, 1, 1, 0, 1, 0);
        chk("R2 rx deferred at write", rdone, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2 rx held while busy", rdone, 0);
        end
        rb = 0;
        @(negedge clk);
        chk("R2 rx done at busy fall", rdone, 1);
        chk("R5 irq on deferred rx", irq, 1);
        @(negedge clk);
        chk("R10 rx deferred one cycle", rdone, 0);

        // R3: deferred transmit stop, mask off
        wr_ctl(0, 1, 1, 0, 1, 1, 0);
        chk("R3 tx deferred at write", tdone, 0);
        repeat (4) @(negedge clk);
        chk("R3 tx held while busy", tdone, 0);
        tb = 0;
        @(negedge clk);
        chk("R3 tx done at busy fall", tdone, 1);
        chk("R5 irq masked tx", irq, 0);

        // R4: cancel pending stops
        wr_ctl(1, 1, 1, 1, 1, 1, 1);
        wr_ctl(0, 0, 1, 1, 1, 1, 1);
        rb = 0; tb = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R4 cancelled no done", {rdone, tdone, irq}, 0);
        end
        mr = 0; mt = 0;

        // R6: polling period and restart
        wr_ctl(0, 0, 0, 0, 0, 0, 0);
        for (int i = 1; i <= T + 4; i++) begin
            @(negedge clk);
            chk("R6 walk period", walk, (i % T == 0) ? 1 : 0);
        end
        wr_ctl(0, 0, 0, 0, 0, 0, 0);
        for (int i = 1; i <= 3 * T; i++) begin
            @(negedge clk);
            chk("R6 walk after rearm", walk, (i % T == 0) ? 1 : 0);
        end

        // R7: transmit stop suppresses walks, timer keeps running
        wr_ctl(0, 1, 0, 0, 0, 0, 0);
        chk("R3 tx immediate with poll", tdone, 1);
        for (int i = 1; i <= 2 * T + 3; i++) begin
            @(negedge clk);
            chk("R7 no walk while stopped", walk, 0);
        end
        wr_ctl(0, 0, 0, 0, 0, 0, 0);
        for (int i = 1; i <= T; i++) begin
            @(negedge clk);
            chk("R7 walk resumes", walk, (i == T) ? 1 : 0);
        end

        // R8: poll-disable stops the timer
        wr_ctl(0, 0, 1, 0, 0, 0, 0);
        for (int i = 1; i <= 3 * T; i++) begin
            @(negedge clk);
            chk("R8 no walk after disable", walk, 0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule